// File: doc/BRIEF.md
# Broadcast-Alias Control Register Block

This block is a memory-mapped control and status register file that sits behind a minimal single-cycle CPU request port. The port carries valid, a write flag, an address and write data, and it returns an acknowledge with read data. A fixed map of 32-bit storage registers drives the hardware through a flat output vector. One register is read-only and reflects a hardware status input. The other registers are read-write or write-only, and each carries a per-bit writable mask.

Besides its real registers, the map holds alias addresses that own no flops. A hit on an alias counts as a hit on every register that the alias names, so one bus write lands in several registers in the same clock cycle. A single-register alias names an explicit list of registers. A group alias covers a window of offsets, and offset k in the window hits offset k inside each target group. A read of an alias returns the OR of the values of those of its targets that can be read.

Top module: `rb_bcast_regs`

## Requirements
- R1: After reset, every read-write and write-only slot of `regs_q` holds its reset value: 0x000000A5 at 0x00, 0x00001234 at 0x08, and zero for all the others. Read-only slots of `regs_q` are always zero. `rsp_ack` and `rsp_rdata` are zero.
- R2: A write to a read-write register changes only the bits in that register's writable mask. The mask is 0x0000FFFF for 0x08, 0x00FF00FF for 0x34, and all ones elsewhere. The new value appears on `regs_q` in the cycle after the request, and a read returns it.
- R3: A read of the read-only register at 0x0C returns the current `sts_in`. A write to it changes no register and no output.
- R4: A write to a write-only register (0x04, 0x44) updates its `regs_q` slot. A read of a write-only register returns zero.
- R5: A write to the single alias at 0x10 loads the write data, masked per target, into 0x00 and 0x08 in the same cycle. All other registers keep their values.
- R6: A write to the group alias offset 0x20+k (k = 0 or 4) loads 0x30+k and 0x40+k in the same cycle, each under its own mask.
- R7: A read of an alias returns the bitwise OR of the values of its readable targets. Write-only targets add nothing to this OR.
- R8: Each accepted request, including back-to-back requests, is acknowledged exactly one cycle later with its read data. With no request, `rsp_ack` is low and `rsp_rdata` is zero.
- R9: A request to an address that matches neither a register nor an alias (for example 0x02, 0x14, 0x28, 0x50) is acknowledged. A read of it returns zero, and a write to it changes nothing.
- R10: Aliases keep no copy of their own. After a direct write to a target, a read of the alias shows the target's new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request valid; accepted every cycle it is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| sts_in | input | N_RO*DATA_W | Status values of the read-only registers |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_ack` |
| regs_q | output | N_REG*DATA_W | Stored register values, slot r in bits r*DATA_W and up |

## Verification
The hardest case to reach is an alias read whose answer cannot be mistaken for a single target's value. The targets must hold different values, and some must be write-only or mask-limited. The stimulus first broadcasts a common pattern. It then rewrites one target directly with bits that are disjoint from the pattern, so the alias read must show the OR of both. On the group alias, one target is write-only, which exposes a design that folds unreadable values into the read. Back-to-back requests check that the response of each request stays matched to that request.

// File: rtl/rb_map_pkg.sv
package rb_map_pkg;

   typedef enum logic [1:0] {
      ACC_RW = 2'd0,
      ACC_RO = 2'd1,
      ACC_WO = 2'd2
   } acc_e;

   localparam int REG_BYTES = 4;
   localparam int N_REG     = 8;

   localparam logic [31:0] REG_ADDR [N_REG] = '{
      32'h00, 32'h04, 32'h08, 32'h0C, 32'h30, 32'h34, 32'h40, 32'h44};
   localparam acc_e REG_ACC [N_REG] = '{
      ACC_RW, ACC_WO, ACC_RW, ACC_RO, ACC_RW, ACC_RW, ACC_RW, ACC_WO};
   localparam logic [31:0] REG_WMASK [N_REG] = '{
      32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000,
      32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
   localparam logic [31:0] REG_RST [N_REG] = '{
      32'h0000_00A5, 32'h0, 32'h0000_1234, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

   // single-register alias and its explicit target list
   localparam logic [31:0] SB_ADDR  = 32'h10;
   localparam int          N_SB_TGT = 2;
   localparam logic [31:0] SB_TGT [N_SB_TGT] = '{32'h00, 32'h08};

   // group alias window and the bases of the groups it mirrors
   localparam logic [31:0] GRP_BASE  = 32'h20;
   localparam int          GRP_SPAN  = 2;
   localparam int          N_GRP_TGT = 2;
   localparam logic [31:0] GRP_TGT [N_GRP_TGT] = '{32'h30, 32'h40};

   // alias 0 is the single alias, aliases 1..GRP_SPAN are the group window
   localparam int N_BC = 1 + GRP_SPAN;

   function automatic logic [31:0] bc_addr(input int b);
      if (b == 0) return SB_ADDR;
      return GRP_BASE + 32'(REG_BYTES * (b - 1));
   endfunction

   function automatic logic [N_REG-1:0] bc_tmask(input int b);
      logic [N_REG-1:0] m;
      m = '0;
      for (int r = 0; r < N_REG; r++) begin
         if (b == 0) begin
            for (int t = 0; t < N_SB_TGT; t++)
               if (REG_ADDR[r] == SB_TGT[t]) m[r] = 1'b1;
         end else begin
            for (int g = 0; g < N_GRP_TGT; g++)
               if (REG_ADDR[r] == GRP_TGT[g] + 32'(REG_BYTES * (b - 1))) m[r] = 1'b1;
         end
      end
      return m;
   endfunction

   function automatic logic [N_BC-1:0] reg_bc_col(input int r);
      logic [N_BC-1:0] c;
      logic [N_REG-1:0] tm;
      c = '0;
      for (int b = 0; b < N_BC; b++) begin
         tm   = bc_tmask(b);
         c[b] = tm[r];
      end
      return c;
   endfunction

   function automatic int ro_count();
      int n;
      n = 0;
      for (int r = 0; r < N_REG; r++) if (REG_ACC[r] == ACC_RO) n++;
      return n;
   endfunction

   function automatic int ro_rank(input int r);
      int n;
      n = 0;
      for (int i = 0; i < r; i++) if (REG_ACC[i] == ACC_RO) n++;
      return n;
   endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode
   import rb_map_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [N_REG-1:0]  wr_stb,
   output logic [N_REG-1:0]  rd_stb
);

   logic [N_BC-1:0]  bc_hit;
   logic [N_REG-1:0] acc_stb;

   for (genvar b = 0; b < N_BC; b++) begin : g_bc
      localparam logic [31:0] BA = bc_addr(b);
      assign bc_hit[b] = (req_addr == ADDR_W'(BA));
   end

   for (genvar r = 0; r < N_REG; r++) begin : g_reg
      localparam logic [N_BC-1:0] COL = reg_bc_col(r);
      logic hit;
      // own match OR any alias naming this register, reads and writes alike
      assign hit = (req_addr == ADDR_W'(REG_ADDR[r])) | (|(bc_hit & COL));
      if (REG_ACC[r] == ACC_RO) begin : g_ro
         assign acc_stb[r] = req_vld & hit & ~req_wr;
      end else if (REG_ACC[r] == ACC_WO) begin : g_wo
         assign acc_stb[r] = req_vld & hit & req_wr;
      end else begin : g_rw
         assign acc_stb[r] = req_vld & hit;
      end
   end

   assign wr_stb = acc_stb & {N_REG{req_wr}};
   assign rd_stb = acc_stb & {N_REG{~req_wr}};

endmodule

// File: rtl/rb_store.sv
module rb_store #(
   parameter int               DATA_W = 32,
   parameter logic [DATA_W-1:0] WMASK = '1,
   parameter logic [DATA_W-1:0] RSTV  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RSTV;
      else if (we) q <= (q & ~WMASK) | (wdata & WMASK);
   end

   // R2: storage moves only under a write strobe
   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   // R2: bits outside the writable mask never leave their reset value
   assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~WMASK) == (RSTV & ~WMASK));

endmodule

// File: rtl/rb_read_or.sv
module rb_read_or #(
   parameter int DATA_W = 32,
   parameter int N_REG  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_vld,
   input  logic [N_REG-1:0]        rd_stb,
   input  logic [N_REG*DATA_W-1:0] rd_val,
   output logic                    rsp_ack,
   output logic [DATA_W-1:0]       rsp_rdata
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int r = 0; r < N_REG; r++)
         if (rd_stb[r]) sel = sel | rd_val[r*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ack   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_ack   <= req_vld;
         rsp_rdata <= sel;
      end
   end

   assert_ack_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_ack);

   assert_no_spurious_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_ack);

   assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_ack |-> (rsp_rdata == '0));

endmodule

// File: rtl/rb_bcast_regs.sv
module rb_bcast_regs
   import rb_map_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int N_RO  = ro_count()
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_vld,
   input  logic                    req_wr,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   input  logic [N_RO*DATA_W-1:0]  sts_in,
   output logic                    rsp_ack,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic [N_REG*DATA_W-1:0] regs_q
);

   // elaboration checks on parameters and the fixed map
   if (DATA_W < 8 || DATA_W > 32) begin : g_chk_dw
      $error("DATA_W must lie in 8..32");
   end
   if (N_RO < 1) begin : g_chk_ro
      $error("map needs at least one read-only register");
   end
   for (genvar r = 0; r < N_REG; r++) begin : g_chk_addr
      if ((REG_ADDR[r] >> ADDR_W) != 0) begin : g_fit
         $error("register address does not fit ADDR_W");
      end
   end
   for (genvar b = 0; b < N_BC; b++) begin : g_chk_bc
      if (bc_tmask(b) == '0) begin : g_empty
         $error("alias without any target");
      end
   end

   logic [N_REG-1:0]        wr_stb;
   logic [N_REG-1:0]        rd_stb;
   logic [N_REG*DATA_W-1:0] rd_val;

   rb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_vld  (req_vld),
      .req_wr   (req_wr),
      .req_addr (req_addr),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb)
   );

   for (genvar r = 0; r < N_REG; r++) begin : g_reg
      if (REG_ACC[r] == ACC_RO) begin : g_ro
         assign rd_val[r*DATA_W +: DATA_W] = sts_in[ro_rank(r)*DATA_W +: DATA_W];
         assign regs_q[r*DATA_W +: DATA_W] = '0;
         // R3: decode never raises a write strobe on a read-only register
         assert_ro_no_wstb_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld && req_wr) |-> !wr_stb[r]);
      end else begin : g_st
         logic [DATA_W-1:0] q;
         rb_store #(
            .DATA_W (DATA_W),
            .WMASK  (DATA_W'(REG_WMASK[r])),
            .RSTV   (DATA_W'(REG_RST[r]))
         ) u_st (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_stb[r]),
            .wdata (req_wdata),
            .q     (q)
         );
         assign rd_val[r*DATA_W +: DATA_W] = q;
         assign regs_q[r*DATA_W +: DATA_W] = q;
      end
   end

   rb_read_or #(.DATA_W(DATA_W), .N_REG(N_REG)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (req_vld),
      .rd_stb    (rd_stb),
      .rd_val    (rd_val),
      .rsp_ack   (rsp_ack),
      .rsp_rdata (rsp_rdata)
   );

   // R5 (alias 0) and R6 (group window): every writable target loads the data
   for (genvar b = 0; b < N_BC; b++) begin : g_fan
      localparam logic [N_REG-1:0] TM = bc_tmask(b);
      localparam logic [31:0]      BA = bc_addr(b);
      for (genvar r = 0; r < N_REG; r++) begin : g_t
         if (TM[r] && REG_ACC[r] != ACC_RO) begin : g_chk
            localparam logic [DATA_W-1:0] M = DATA_W'(REG_WMASK[r]);
            assert_bcast_fanout_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (req_vld && req_wr && req_addr == ADDR_W'(BA)) |=>
               ((regs_q[r*DATA_W +: DATA_W] & M) == ($past(req_wdata) & M)));
         end
      end
   end

endmodule

// File: tb/tb_rb_bcast_regs.sv
module tb_rb_bcast_regs;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_vld, req_wr;
   logic [7:0]  req_addr;
   logic [31:0] req_wdata;
   logic [31:0] sts_in;
   logic        rsp_ack;
   logic [31:0] rsp_rdata;
   logic [255:0] regs_q;

   int n_tot = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench view of the map, written from the requirements
   localparam logic [31:0] MSK [8] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0,
                                       32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
   localparam logic [7:0] IS_RO = 8'b0000_1000;
   localparam logic [7:0] IS_WO = 8'b1000_0010;
   logic [31:0] m [8];

   always #2 clk = ~clk;

   rb_bcast_regs dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .sts_in(sts_in),
      .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .regs_q(regs_q));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tgt(input logic [7:0] a);
      case (a)
         8'h00: return 8'b0000_0001;
         8'h04: return 8'b0000_0010;
         8'h08: return 8'b0000_0100;
         8'h0C: return 8'b0000_1000;
         8'h30: return 8'b0001_0000;
         8'h34: return 8'b0010_0000;
         8'h40: return 8'b0100_0000;
         8'h44: return 8'b1000_0000;
         8'h10: return 8'b0000_0101;
         8'h20: return 8'b0101_0000;
         8'h24: return 8'b1010_0000;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] rd_model(input logic [7:0] a);
      logic [31:0] v;
      logic [7:0]  t;
      v = '0;
      t = tgt(a);
      for (int r = 0; r < 8; r++)
         if (t[r] && !IS_WO[r]) v = v | (IS_RO[r] ? sts_in : m[r]);
      return v;
   endfunction

   task automatic check_outs(input string tag);
      for (int r = 0; r < 8; r++)
         chk(tag, regs_q[r*32 +: 32], IS_RO[r] ? 32'h0 : m[r]);
   endtask

   task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
      logic [7:0] t;
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_vld = 1'b0;
      rd = rsp_rdata;
      chk("R8 ack after request", {31'b0, rsp_ack}, 32'h1);
      if (wr) begin
         t = tgt(a);
         for (int r = 0; r < 8; r++)
            if (t[r] && !IS_RO[r]) m[r] = (m[r] & ~MSK[r]) | (d & MSK[r]);
      end
   endtask

   task automatic rd_check(input string tag, input logic [7:0] a);
      logic [31:0] v;
      bus(1'b0, a, 32'h0, v);
      chk(tag, v, rd_model(a));
   endtask

   task automatic t_reset();
      check_outs("R1 reset slot");
      chk("R1 reset ack", {31'b0, rsp_ack}, 32'h0);
      chk("R1 reset rdata", rsp_rdata, 32'h0);
      chk("R1 reset value 0x00", regs_q[31:0], 32'h0000_00A5);
   endtask

   task automatic t_direct_rw();
      logic [31:0] v;
      bus(1'b1, 8'h00, 32'hDEAD_BEEF, v);
      check_outs("R2 write 0x00 outputs");
      rd_check("R2 read 0x00", 8'h00);
      bus(1'b1, 8'h08, 32'hFFFF_5678, v);
      chk("R2 masked write 0x08", regs_q[95:64], 32'h0000_5678);
      rd_check("R2 read 0x08", 8'h08);
      bus(1'b1, 8'h34, 32'hABCD_1234, v);
      chk("R2 masked write 0x34", regs_q[191:160], 32'h00CD_0034);
   endtask

   task automatic t_ro();
      logic [31:0] v;
      rd_check("R3 read status", 8'h0C);
      bus(1'b1, 8'h0C, 32'h1234_5678, v);
      check_outs("R3 write to read-only ignored");
      rd_check("R3 read status after write", 8'h0C);
      sts_in = 32'h0BAD_F00D;
      rd_check("R3 read changed status", 8'h0C);
   endtask

   task automatic t_wo();
      logic [31:0] v;
      bus(1'b1, 8'h04, 32'h1357_2468, v);
      chk("R4 write-only output", regs_q[63:32], 32'h1357_2468);
      bus(1'b0, 8'h04, 32'h0, v);
      chk("R4 write-only reads zero", v, 32'h0);
   endtask

   task automatic t_bcast_single();
      logic [31:0] v;
      bus(1'b1, 8'h10, 32'hA5A5_C3C3, v);
      chk("R5 alias target 0x00", regs_q[31:0], 32'hA5A5_C3C3);
      chk("R5 alias target 0x08 masked", regs_q[95:64], 32'h0000_C3C3);
      check_outs("R5 other registers untouched");
      rd_check("R7 read single alias", 8'h10);
      bus(1'b1, 8'h00, 32'h00F0_0000, v);
      bus(1'b0, 8'h10, 32'h0, v);
      chk("R10 alias read after direct write", v, 32'h00F0_C3C3);
   endtask

   task automatic t_bcast_group();
      logic [31:0] v;
      bus(1'b1, 8'h20, 32'h1111_2222, v);
      chk("R6 group k=0 to 0x30", regs_q[159:128], 32'h1111_2222);
      chk("R6 group k=0 to 0x40", regs_q[223:192], 32'h1111_2222);
      bus(1'b1, 8'h24, 32'h3333_4444, v);
      chk("R6 group k=4 to 0x34 masked", regs_q[191:160], 32'h0033_0044);
      chk("R6 group k=4 to 0x44", regs_q[255:224], 32'h3333_4444);
      check_outs("R6 group outputs");
      bus(1'b1, 8'h40, 32'h8000_0001, v);
      bus(1'b0, 8'h20, 32'h0, v);
      chk("R7 R10 group alias OR", v, 32'h9111_2223);
      bus(1'b0, 8'h24, 32'h0, v);
      chk("R7 write-only target excluded", v, 32'h0033_0044);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus(1'b1, 8'h14, 32'hFFFF_FFFF, v);
      bus(1'b1, 8'h50, 32'hFFFF_FFFF, v);
      bus(1'b1, 8'h28, 32'hFFFF_FFFF, v);
      bus(1'b1, 8'h02, 32'hFFFF_FFFF, v);
      check_outs("R9 unmapped writes ignored");
      bus(1'b0, 8'h14, 32'h0, v);
      chk("R9 unmapped read 0x14", v, 32'h0);
      bus(1'b0, 8'h50, 32'h0, v);
      chk("R9 unmapped read 0x50", v, 32'h0);
   endtask

   task automatic t_ack_b2b();
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = 8'h00;
      @(negedge clk);
      chk("R8 b2b first ack", {31'b0, rsp_ack}, 32'h1);
      chk("R8 b2b first data", rsp_rdata, m[0]);
      req_addr = 8'h0C;
      @(negedge clk);
      req_vld = 1'b0;
      chk("R8 b2b second ack", {31'b0, rsp_ack}, 32'h1);
      chk("R8 b2b second data", rsp_rdata, sts_in);
      @(negedge clk);
      chk("R8 idle ack low", {31'b0, rsp_ack}, 32'h0);
      chk("R8 idle data zero", rsp_rdata, 32'h0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_tot++;
         n_bad++;
         $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0;
      req_addr = '0; req_wdata = '0; sts_in = 32'hCAFE_0003;
      m = '{32'h0000_00A5, 32'h0, 32'h0000_1234, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct_rw();
      t_ro();
      t_wo();
      t_bcast_single();
      t_bcast_group();
      t_unmapped();
      t_ack_b2b();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

endmodule